// File: doc/BRIEF.md
# Store Buffer with Typed Fences

This block sits between a single processor core and the coherence port that propagates its writes to other caches. A store is retired into a small in-order buffer the moment the core presents it, so the core never waits for the remote update or invalidate to be acknowledged. The buffer drains to the coherence port one entry at a time, oldest first. An entry is released only when the acknowledgement for its update comes back.

Loads go straight to the local cache read port, even while older stores to other addresses are still waiting for acknowledgement. Such a load can therefore see a stale value. A load whose address matches a buffered store takes its data from the youngest such store. Three fence kinds let software win back ordering where it needs it. Each fence holds the request port until its wait condition is met, then finishes with a one-cycle done pulse and causes no memory traffic. Every request uses one in-order handshake port, so fences stay in program order with each other and with the accesses around them.

Encodings: `reqOp` is 0 for a load, 1 for a store, 2 for a fence and 3 for a no-op. `reqFence` is 0 for a full fence, 1 for a store-to-load fence, 2 for a load-to-load fence, and 3 acts as a full fence.

Top module: `store_order_unit`

## Requirements
- R1: A store (reqOp=1) is accepted with reqReady high whenever the buffer has a free entry, without waiting for any acknowledgement. A further request can be accepted in the very next cycle.
- R2: With all 4 entries occupied, reqReady is low for a store and stays low until an acknowledgement frees an entry. The stalled store is then accepted.
- R3: Buffered stores appear on updValid/updAddr/updData one at a time, oldest first. A held offer keeps its address and data while updReady is low. After the handshake, updValid stays low until the acknowledgement for that update returns.
- R4: An entry is freed only by updAck for the update in flight. An updAck with no update in flight changes nothing.
- R5: A load (reqOp=0) whose address matches no buffered store drives cacheRdValid and cacheRdAddr in its acceptance cycle, even while older stores are unacknowledged. Its data comes back on rspValid/rspData in the cycle that cacheRspValid/cacheRspData arrive.
- R6: A load whose address matches one or more buffered stores issues no cache read. It returns the youngest matching store's data on rspValid one cycle after acceptance.
- R7: A matching load waits while any cache read is outstanding, so load responses keep program order. At most 4 cache reads may be outstanding; a fifth missing load waits until a response returns.
- R8: A full fence (reqFence=0) is accepted only when the buffer is empty and no load is outstanding. fenceDone pulses for exactly one cycle after acceptance, with no cache read and no buffer entry.
- R9: A store-to-load fence (reqFence=1) waits only until all buffered stores are acknowledged; outstanding loads do not hold it.
- R10: A load-to-load fence (reqFence=2) waits only until all outstanding loads have returned; unacknowledged stores do not hold it.
- R11: After reset the buffer is empty, so reqReady is high for a store, and updValid, cacheRdValid, rspValid and fenceDone are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Core request accepted this cycle |
| reqOp | input | 2 | 0 load, 1 store, 2 fence, 3 no-op |
| reqFence | input | 2 | 0 full, 1 store-to-load, 2 load-to-load |
| reqAddr | input | AddrW | Request address |
| reqData | input | DataW | Store data |
| rspValid | output | 1 | Load data valid |
| rspData | output | DataW | Load data |
| fenceDone | output | 1 | One-cycle fence completion pulse |
| updValid | output | 1 | Update message valid |
| updReady | input | 1 | Coherence port takes the update |
| updAddr | output | AddrW | Update address |
| updData | output | DataW | Update data |
| updAck | input | 1 | Acknowledgement of the update in flight |
| cacheRdValid | output | 1 | Local cache read request |
| cacheRdAddr | output | AddrW | Local cache read address |
| cacheRspValid | input | 1 | Local cache read data valid, at least one cycle after its request |
| cacheRspData | input | DataW | Local cache read data |

## Verification
The hardest states to reach are those where both kinds of outstanding work overlap: unacknowledged stores in the buffer while cache reads are still pending. The two partial fences disagree only there. The bench builds these states by holding updReady and updAck low to keep stores parked, and by withholding cache responses to keep loads open. It then offers each fence kind in turn and releases the two kinds of work one at a time. The same withholding of responses forces a matching load to wait behind an older cache read, and fills the outstanding-read limit.

// File: rtl/sou_pkg.sv
package sou_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_NONE  = 2'd3
  } reqOp_e;

  typedef enum logic [1:0] {
    FN_FULL = 2'd0,
    FN_STLD = 2'd1,
    FN_LDLD = 2'd2,
    FN_RSVD = 2'd3
  } fenceKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic fwdCapture;
    logic fwdSel;
  } bufStrobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic empty;
    logic full;
    logic hit;
  } bufStatus_t;

endpackage

// File: rtl/sou_datapath.sv
module sou_datapath
  import sou_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int DataW = 32,
  parameter int Depth = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufStrobe_t       strobe,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqData,
  input  logic [DataW-1:0] cacheRspData,
  output bufStatus_t       status,
  output logic [AddrW-1:0] updAddr,
  output logic [DataW-1:0] updData,
  output logic [DataW-1:0] rspData
);

  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);

  logic [AddrW-1:0] addrQ [Depth];
  logic [DataW-1:0] dataQ [Depth];
  logic [PtrW-1:0]  rdPtr, wrPtr;
  logic [CntW-1:0]  count;
  logic             hit;
  logic [DataW-1:0] hitData;
  logic [DataW-1:0] fwdData;

  function automatic logic [PtrW-1:0] nextPtr(input logic [PtrW-1:0] p);
    return (p == PtrW'(Depth - 1)) ? '0 : p + 1'b1;
  endfunction

  // entry storage, written at the tail
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrQ[wrPtr] <= reqAddr;
      dataQ[wrPtr] <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // youngest-match search: walk oldest to youngest, last match wins
  always_comb begin
    logic [PtrW:0] sumIdx;
    hit     = 1'b0;
    hitData = '0;
    for (int k = 0; k < Depth; k++) begin
      sumIdx = (PtrW+1)'(rdPtr) + (PtrW+1)'(k);
      if (sumIdx >= (PtrW+1)'(Depth)) sumIdx = sumIdx - (PtrW+1)'(Depth);
      if (CntW'(k) < count && addrQ[sumIdx[PtrW-1:0]] == reqAddr) begin
        hit     = 1'b1;
        hitData = dataQ[sumIdx[PtrW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  fwdData <= '0;
    else if (strobe.fwdCapture) fwdData <= hitData;
  end

  assign status.empty = (count == '0);
  assign status.full  = (count == CntW'(Depth));
  assign status.hit   = hit;
  assign updAddr      = addrQ[rdPtr];
  assign updData      = dataQ[rdPtr];
  assign rspData      = strobe.fwdSel ? fwdData : cacheRspData;

  // R2: the control never pushes into a full buffer
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !status.full);

  // R4: an entry is freed only while one is held
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !status.empty);

  // R3: the offered head does not change without a pop
  assert_head_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pop && !status.empty) |=> ($stable(updAddr) && $stable(updData)));

endmodule

// File: rtl/sou_control.sv
module sou_control
  import sou_pkg::*;
#(
  parameter int MaxLoads = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqFence,
  input  bufStatus_t status,
  input  logic       updReady,
  input  logic       updAck,
  input  logic       cacheRspValid,
  output logic       reqReady,
  output bufStrobe_t strobe,
  output logic       updValid,
  output logic       cacheRdValid,
  output logic       rspValid,
  output logic       fenceDone
);

  localparam int LdW = $clog2(MaxLoads + 1);

  logic [LdW-1:0] loadsOut;
  logic           inFlight;
  logic           fwdValid;
  logic           fenceDoneQ;
  logic           isLoad, isStore, isFence;
  logic           loadsIdle, storesIdle;
  logic           accept, issueRd;

  assign isLoad  = (reqOp == OP_LOAD);
  assign isStore = (reqOp == OP_STORE);
  assign isFence = (reqOp == OP_FENCE);

  assign loadsIdle  = (loadsOut == '0) && !fwdValid;
  assign storesIdle = status.empty;

  always_comb begin
    reqReady = 1'b1;
    if (isStore) begin
      reqReady = !status.full;
    end else if (isLoad) begin
      reqReady = status.hit ? (loadsOut == '0) : (loadsOut < LdW'(MaxLoads));
    end else if (isFence) begin
      case (reqFence)
        FN_STLD: reqReady = storesIdle;
        FN_LDLD: reqReady = loadsIdle;
        default: reqReady = storesIdle && loadsIdle;
      endcase
    end
  end

  assign accept  = reqValid && reqReady;
  assign issueRd = accept && isLoad && !status.hit;

  assign cacheRdValid      = issueRd;
  assign strobe.push       = accept && isStore;
  assign strobe.pop        = inFlight && updAck;
  assign strobe.fwdCapture = accept && isLoad && status.hit;
  assign strobe.fwdSel     = fwdValid;
  assign updValid          = !status.empty && !inFlight;
  assign rspValid          = fwdValid || cacheRspValid;
  assign fenceDone         = fenceDoneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadsOut   <= '0;
      inFlight   <= 1'b0;
      fwdValid   <= 1'b0;
      fenceDoneQ <= 1'b0;
    end else begin
      case ({issueRd, cacheRspValid})
        2'b10:   loadsOut <= loadsOut + 1'b1;
        2'b01:   loadsOut <= loadsOut - 1'b1;
        default: loadsOut <= loadsOut;
      endcase
      if (updValid && updReady)   inFlight <= 1'b1;
      else if (inFlight && updAck) inFlight <= 1'b0;
      fwdValid   <= strobe.fwdCapture;
      fenceDoneQ <= accept && isFence;
    end
  end

  // R7: outstanding cache reads never exceed the limit
  assert_load_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadsOut <= LdW'(MaxLoads));

  // R7: a forwarded response never collides with a cache response
  assert_rsp_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> !cacheRspValid);

  // R3: an offered update is held until taken
  assert_upd_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updReady) |=> updValid);

  // R4: the update in flight still owns its buffer entry
  assert_inflight_owned_R4: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !status.empty);

  // R8: a fence completion is preceded by a fence acceptance with no read
  assert_fence_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isFence) |=> (fenceDone && !$past(cacheRdValid)));

endmodule

// File: rtl/store_order_unit.sv
module store_order_unit
  import sou_pkg::*;
#(
  parameter int AddrW    = 16,
  parameter int DataW    = 32,
  parameter int Depth    = 4,
  parameter int MaxLoads = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqFence,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqData,
  output logic             rspValid,
  output logic [DataW-1:0] rspData,
  output logic             fenceDone,
  output logic             updValid,
  input  logic             updReady,
  output logic [AddrW-1:0] updAddr,
  output logic [DataW-1:0] updData,
  input  logic             updAck,
  output logic             cacheRdValid,
  output logic [AddrW-1:0] cacheRdAddr,
  input  logic             cacheRspValid,
  input  logic [DataW-1:0] cacheRspData
);

  bufStrobe_t strobe;
  bufStatus_t status;

  sou_control #(.MaxLoads(MaxLoads)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqFence     (reqFence),
    .status       (status),
    .updReady     (updReady),
    .updAck       (updAck),
    .cacheRspValid(cacheRspValid),
    .reqReady     (reqReady),
    .strobe       (strobe),
    .updValid     (updValid),
    .cacheRdValid (cacheRdValid),
    .rspValid     (rspValid),
    .fenceDone    (fenceDone)
  );

  sou_datapath #(.AddrW(AddrW), .DataW(DataW), .Depth(Depth)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .cacheRspData(cacheRspData),
    .status      (status),
    .updAddr     (updAddr),
    .updData     (updData),
    .rspData     (rspData)
  );

  assign cacheRdAddr = reqAddr;

endmodule

// File: tb/tb_store_order_unit.sv
`timescale 1ns/1ps
module tb_store_order_unit;

  localparam int AddrW = 16;
  localparam int DataW = 32;

  logic             clk = 1'b0;
  logic             rstN;
  logic             reqValid;
  logic             reqReady;
  logic [1:0]       reqOp;
  logic [1:0]       reqFence;
  logic [AddrW-1:0] reqAddr;
  logic [DataW-1:0] reqData;
  logic             rspValid;
  logic [DataW-1:0] rspData;
  logic             fenceDone;
  logic             updValid;
  logic             updReady;
  logic [AddrW-1:0] updAddr;
  logic [DataW-1:0] updData;
  logic             updAck;
  logic             cacheRdValid;
  logic [AddrW-1:0] cacheRdAddr;
  logic             cacheRspValid;
  logic [DataW-1:0] cacheRspData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  store_order_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqFence(reqFence), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .fenceDone(fenceDone),
    .updValid(updValid), .updReady(updReady), .updAddr(updAddr),
    .updData(updData), .updAck(updAck), .cacheRdValid(cacheRdValid),
    .cacheRdAddr(cacheRdAddr), .cacheRspValid(cacheRspValid),
    .cacheRspData(cacheRspData)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic drive(input logic [1:0] op, input logic [1:0] kind,
                       input logic [AddrW-1:0] a, input logic [DataW-1:0] d);
    reqValid = 1'b1; reqOp = op; reqFence = kind; reqAddr = a; reqData = d;
  endtask

  task automatic idle();
    reqValid = 1'b0; reqOp = 2'd3; reqFence = 2'd0; reqAddr = '0; reqData = '0;
  endtask

  function automatic logic [DataW-1:0] stv(input logic [AddrW-1:0] a, input int n);
    return {8'hA5, 8'(n), a};
  endfunction

  // push one store that must be accepted at once
  task automatic pushStore(input string tag, input logic [AddrW-1:0] a, input logic [DataW-1:0] d);
    drive(2'd1, 2'd0, a, d);
    settle();
    chk(tag, reqReady, 1'b1);
    tick();
    idle();
  endtask

  // take one update off the head and acknowledge it
  task automatic drainOne(input string tag, input logic [AddrW-1:0] a, input logic [DataW-1:0] d);
    updReady = 1'b1;
    settle();
    chk(tag, updValid, 1'b1);
    chk(tag, updAddr, a);
    chk(tag, updData, d);
    tick();
    updReady = 1'b0;
    settle();
    chk({tag, " one in flight"}, updValid, 1'b0);
    updAck = 1'b1;
    tick();
    updAck = 1'b0;
  endtask

  task automatic testReset();
    drive(2'd1, 2'd0, 16'h0, 32'h0);
    reqValid = 1'b0;
    settle();
    chk("R11 store ready", reqReady, 1'b1);
    chk("R11 updValid", updValid, 1'b0);
    chk("R11 cacheRdValid", cacheRdValid, 1'b0);
    chk("R11 rspValid", rspValid, 1'b0);
    chk("R11 fenceDone", fenceDone, 1'b0);
    idle();
    tick();
  endtask

  task automatic testStoresDrain();
    updReady = 1'b0;
    pushStore("R1 first store", 16'h0100, stv(16'h0100, 1));
    drive(2'd1, 2'd0, 16'h0200, stv(16'h0200, 2));
    settle();
    chk("R1 back-to-back store", reqReady, 1'b1);
    chk("R3 head offered", updAddr, 16'h0100);
    tick();
    idle();
    settle();
    chk("R3 hold valid", updValid, 1'b1);
    chk("R3 hold addr", updAddr, 16'h0100);
    updAck = 1'b1;          // nothing in flight
    tick();
    updAck = 1'b0;
    settle();
    chk("R4 stray ack ignored", updAddr, 16'h0100);
    chk("R4 stray ack data", updData, stv(16'h0100, 1));
    drainOne("R3 oldest first", 16'h0100, stv(16'h0100, 1));
    drainOne("R3 second", 16'h0200, stv(16'h0200, 2));
    settle();
    chk("R4 empty after acks", updValid, 1'b0);
  endtask

  task automatic testFull();
    updReady = 1'b0;
    for (int i = 0; i < 4; i++)
      pushStore("R2 fill", 16'h0010 + 16'(i), stv(16'h0010 + 16'(i), i));
    drive(2'd1, 2'd0, 16'h0014, stv(16'h0014, 4));
    settle();
    chk("R2 full stalls store", reqReady, 1'b0);
    tick();
    settle();
    chk("R2 still stalled", reqReady, 1'b0);
    updReady = 1'b1;
    tick();
    updReady = 1'b0;
    settle();
    chk("R4 in flight keeps entry", reqReady, 1'b0);
    updAck = 1'b1;
    tick();
    updAck = 1'b0;
    settle();
    chk("R2 ack frees entry", reqReady, 1'b1);
    tick();
    idle();
    for (int i = 1; i < 5; i++)
      drainOne("R3 full drain order", 16'h0010 + 16'(i), stv(16'h0010 + 16'(i), i));
  endtask

  task automatic testLoads();
    updReady = 1'b0;
    pushStore("R5 park store", 16'h0040, stv(16'h0040, 1));
    drive(2'd0, 2'd0, 16'h0050, '0);
    settle();
    chk("R5 load ready", reqReady, 1'b1);
    chk("R5 cache read", cacheRdValid, 1'b1);
    chk("R5 cache addr", cacheRdAddr, 16'h0050);
    chk("R5 store still pending", updValid, 1'b1);
    tick();
    idle();
    cacheRspValid = 1'b1; cacheRspData = 32'h0BAD_0050;
    settle();
    chk("R5 rsp valid", rspValid, 1'b1);
    chk("R5 rsp data", rspData, 32'h0BAD_0050);
    tick();
    cacheRspValid = 1'b0;
    // forwarding from the youngest match
    pushStore("R6 store b", 16'h0060, stv(16'h0060, 2));
    pushStore("R6 store c", 16'h0040, stv(16'h0040, 3));
    drive(2'd0, 2'd0, 16'h0040, '0);
    settle();
    chk("R6 hit ready", reqReady, 1'b1);
    chk("R6 no cache read", cacheRdValid, 1'b0);
    tick();
    idle();
    settle();
    chk("R6 fwd valid", rspValid, 1'b1);
    chk("R6 youngest data", rspData, stv(16'h0040, 3));
    tick();
    settle();
    chk("R6 single response", rspValid, 1'b0);
    // forwarding waits behind a cache read
    drive(2'd0, 2'd0, 16'h0070, '0);
    tick();
    drive(2'd0, 2'd0, 16'h0060, '0);
    settle();
    chk("R7 hit waits", reqReady, 1'b0);
    tick();
    cacheRspValid = 1'b1; cacheRspData = 32'h0BAD_0070;
    settle();
    chk("R7 older rsp first", rspData, 32'h0BAD_0070);
    tick();
    cacheRspValid = 1'b0;
    settle();
    chk("R7 hit released", reqReady, 1'b1);
    tick();
    idle();
    settle();
    chk("R7 fwd after", rspData, stv(16'h0060, 2));
    tick();
    // outstanding read limit
    for (int i = 0; i < 4; i++) begin
      drive(2'd0, 2'd0, 16'h0080 + 16'(i), '0);
      settle();
      chk("R7 read slot", reqReady, 1'b1);
      tick();
    end
    drive(2'd0, 2'd0, 16'h0084, '0);
    settle();
    chk("R7 fifth read stalls", reqReady, 1'b0);
    cacheRspValid = 1'b1; cacheRspData = 32'h1;
    tick();
    cacheRspValid = 1'b0;
    settle();
    chk("R7 slot freed", reqReady, 1'b1);
    tick();
    idle();
    for (int i = 0; i < 4; i++) begin
      cacheRspValid = 1'b1;
      tick();
    end
    cacheRspValid = 1'b0;
  endtask

  task automatic testFences();
    // three stores still parked, no loads open
    updReady = 1'b0;
    drive(2'd2, 2'd1, '0, '0);
    settle();
    chk("R9 waits for stores", reqReady, 1'b0);
    drive(2'd2, 2'd0, '0, '0);
    settle();
    chk("R8 waits for stores", reqReady, 1'b0);
    drive(2'd2, 2'd2, '0, '0);
    settle();
    chk("R10 ignores stores", reqReady, 1'b1);
    chk("R8 fence no read", cacheRdValid, 1'b0);
    tick();
    idle();
    settle();
    chk("R10 done pulse", fenceDone, 1'b1);
    tick();
    settle();
    chk("R8 pulse one cycle", fenceDone, 1'b0);
    // open a load, stores still parked
    drive(2'd0, 2'd0, 16'h0090, '0);
    tick();
    drive(2'd2, 2'd2, '0, '0);
    settle();
    chk("R10 waits for load", reqReady, 1'b0);
    idle();
    drainOne("R9 drain a", 16'h0040, stv(16'h0040, 1));
    drainOne("R9 drain b", 16'h0060, stv(16'h0060, 2));
    drainOne("R9 drain c", 16'h0040, stv(16'h0040, 3));
    drive(2'd2, 2'd1, '0, '0);
    settle();
    chk("R9 ignores loads", reqReady, 1'b1);
    tick();
    drive(2'd2, 2'd0, '0, '0);
    settle();
    chk("R9 done pulse", fenceDone, 1'b1);
    chk("R8 waits for load", reqReady, 1'b0);
    tick();
    cacheRspValid = 1'b1; cacheRspData = 32'h2;
    tick();
    cacheRspValid = 1'b0;
    settle();
    chk("R8 ready when quiet", reqReady, 1'b1);
    chk("R8 no store entry", updValid, 1'b0);
    tick();
    idle();
    settle();
    chk("R8 done pulse", fenceDone, 1'b1);
    tick();
  endtask

  initial begin
    rstN = 1'b0; updReady = 1'b0; updAck = 1'b0;
    cacheRspValid = 1'b0; cacheRspData = '0;
    idle();
    repeat (3) tick();
    settle();
    chk("R11 during reset", updValid, 1'b0);
    rstN = 1'b1;
    tick();
    testReset();
    testStoresDrain();
    testFull();
    testLoads();
    testFences();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule